// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It takes the memory device from reset to an operational state. Coming out of reset, it holds the clock enable low and drives no-operation commands while it counts a long stabilization interval. It then raises the clock enable and issues the fixed start-up command sequence, leaving a programmed gap in clock cycles between consecutive commands.

The sequence has these steps in this order:
- precharge all banks;
- enable the delay-locked loop through the extended mode register;
- load the mode register with the DLL-reset bit set;
- precharge all banks a second time;
- issue a configurable number of auto-refresh commands;
- load the mode register with the DLL-reset bit cleared.

A parameter swaps the DLL-reset load and the second precharge. Every delay is set at elaboration in clock cycles. The block waits for a DLL lock window that starts at the DLL-enable command. Once the final spacing and the lock window have both run out, it raises a sticky done flag. It then leaves the command bus at no-operation so that normal scheduling logic can take over.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset is released, cke_o is low and the command is NOP for the first STARTUP_CYC cycles. In cycle STARTUP_CYC, cke_o goes high with a NOP, and cke_o then stays high until the next reset. An asserted reset returns the block to this state at once.
- R2: Commands are encoded on {cs_n_o, ras_n_o, cas_n_o, we_n_o} as follows: NOP = 0111, precharge = 0010, auto-refresh = 0001, mode/extended-mode load = 0000. For a mode load, ba_o = 00 selects the mode register and ba_o = 01 selects the extended register.
- R3: The first command is a precharge-all (addr_o bit 10 high, all other address bits low, ba_o = 0). It is issued one cycle after cke_o rises.
- R4: The extended-mode load (ba_o = 01, addr_o = EXT_VAL) follows the first precharge after T_RP cycles.
- R5: The DLL-reset load (ba_o = 00, addr_o = MODE_VAL with bit 8 set) is always followed by T_MRD cycles of spacing. With DLL_RST_FIRST = 1 it comes T_MRD after the extended load, and the second precharge comes T_MRD after it. With DLL_RST_FIRST = 0 the second precharge comes T_MRD after the extended load, and the DLL-reset load comes T_RP after that precharge.
- R6: The second precharge-all uses the same address as R3 and is followed by T_RP cycles before the next command.
- R7: Exactly N_REF auto-refresh commands are issued, each T_RFC cycles after the previous one. The final mode load comes T_RFC after the last refresh.
- R8: The final mode load has ba_o = 00 and addr_o = MODE_VAL with bit 8 cleared.
- R9: init_done_o rises in the cycle after both of these conditions are met: T_MRD cycles have passed since the final mode load, and R11 is satisfied. It stays high until reset, and from then on the block drives only NOP with cke_o high.
- R10: Every non-NOP command lasts one cycle, and NOP is driven on every cycle between commands.
- R11: init_done_o is not raised until at least DLL_LOCK cycles have passed since the extended-mode load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_o | output | 1 | Clock enable to the device |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| init_done_o | output | 1 | Sequence complete, sticky until reset |

## Verification
The block's only inputs are clock and reset, so the assertions assume only that the timing parameters are at least 2 cycles, which keeps any two commands from landing on adjacent cycles. The bench builds two instances with short delays: one uses the DLL-reset-first order with a short lock window, the other uses the swapped order with a lock window long enough to hold back the done flag. An asynchronous reset issued after completion then checks that the whole sequence restarts from the cold state.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_WAIT, ST_PRE1, ST_EMRS, ST_MRS_RST, ST_PRE2,
    ST_REF, ST_MRS_OP, ST_DONE, ST_IDLE
  } step_e;

  localparam int unsigned A10_BIT = 10;
  localparam int unsigned A8_BIT  = 8;
endpackage

// File: rtl/ddr_init_cnt.sv
module ddr_init_cnt #(
  parameter int unsigned   W    = 8,
  parameter logic [W-1:0]  INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= INIT;
    else if (load_i)              cnt_q <= load_val_i;
    else if (en_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_enc.sv
module ddr_init_enc
  import ddr_init_pkg::*;
#(
  parameter int unsigned           ADDR_W   = 13,
  parameter int unsigned           BA_W     = 2,
  parameter logic [ADDR_W-1:0]     MODE_VAL = 'h031,
  parameter logic [ADDR_W-1:0]     EXT_VAL  = '0
) (
  input  step_e             step_i,
  input  logic              fire_i,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (fire_i) begin
      case (step_i)
        ST_PRE1, ST_PRE2: begin
          cmd_o           = CMD_PRE;
          addr_o[A10_BIT] = 1'b1;
        end
        ST_EMRS: begin
          cmd_o  = CMD_MRS;
          ba_o   = BA_W'(1);
          addr_o = EXT_VAL;
        end
        ST_MRS_RST: begin
          cmd_o          = CMD_MRS;
          addr_o         = MODE_VAL;
          addr_o[A8_BIT] = 1'b1;
        end
        ST_MRS_OP: begin
          cmd_o          = CMD_MRS;
          addr_o         = MODE_VAL;
          addr_o[A8_BIT] = 1'b0;
        end
        ST_REF:  cmd_o = CMD_REF;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 13,
  parameter int unsigned       BA_W          = 2,
  parameter int unsigned       STARTUP_CYC   = 20000,
  parameter int unsigned       T_RP          = 3,
  parameter int unsigned       T_RFC         = 10,
  parameter int unsigned       T_MRD         = 2,
  parameter int unsigned       DLL_LOCK      = 200,
  parameter int unsigned       N_REF         = 2,
  parameter bit                DLL_RST_FIRST = 1'b1,
  parameter logic [ADDR_W-1:0] MODE_VAL      = 'h031,
  parameter logic [ADDR_W-1:0] EXT_VAL       = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);
  localparam int unsigned M1     = (STARTUP_CYC > T_RFC) ? STARTUP_CYC : T_RFC;
  localparam int unsigned M2     = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int unsigned MAXV   = (M1 > M2) ? M1 : M2;
  localparam int unsigned CNT_W  = $clog2(MAXV + 1);
  localparam int unsigned LOCK_W = $clog2(DLL_LOCK + 1);
  localparam int unsigned REF_W  = $clog2(N_REF + 1);

  step_e              step_q, step_d;
  logic [CNT_W-1:0]   gap_ld;
  logic [REF_W-1:0]   ref_q;
  logic               gap_zero, lock_zero, lock_armed_q, lock_ok;
  logic               cke_q, done_q, fire;
  logic [3:0]         cmd;

  ddr_init_cnt #(.W(CNT_W), .INIT(CNT_W'(STARTUP_CYC - 1))) i_gap (
    .clk_i, .rst_ni, .en_i(1'b1), .load_i(fire), .load_val_i(gap_ld), .zero_o(gap_zero)
  );

  // lock window runs from the extended-mode load
  ddr_init_cnt #(.W(LOCK_W), .INIT(LOCK_W'(DLL_LOCK - 1))) i_lock (
    .clk_i, .rst_ni, .en_i(lock_armed_q), .load_i(1'b0), .load_val_i('0), .zero_o(lock_zero)
  );

  assign lock_ok = lock_armed_q && lock_zero;
  assign fire    = gap_zero && (step_q != ST_IDLE) && !(step_q == ST_DONE && !lock_ok);

  always_comb begin
    step_d = step_q;
    gap_ld = '0;
    case (step_q)
      ST_WAIT:    begin step_d = ST_PRE1;  gap_ld = CNT_W'(1);         end
      ST_PRE1:    begin step_d = ST_EMRS;  gap_ld = CNT_W'(T_RP - 1);  end
      ST_EMRS:    begin
        step_d = DLL_RST_FIRST ? ST_MRS_RST : ST_PRE2;
        gap_ld = CNT_W'(T_MRD - 1);
      end
      ST_MRS_RST: begin
        step_d = DLL_RST_FIRST ? ST_PRE2 : ST_REF;
        gap_ld = CNT_W'(T_MRD - 1);
      end
      ST_PRE2:    begin
        step_d = DLL_RST_FIRST ? ST_REF : ST_MRS_RST;
        gap_ld = CNT_W'(T_RP - 1);
      end
      ST_REF:     begin
        step_d = (ref_q == REF_W'(N_REF - 1)) ? ST_MRS_OP : ST_REF;
        gap_ld = CNT_W'(T_RFC - 1);
      end
      ST_MRS_OP:  begin step_d = ST_DONE;  gap_ld = CNT_W'(T_MRD - 1); end
      ST_DONE:    step_d = ST_IDLE;
      default:    step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q       <= ST_WAIT;
      ref_q        <= '0;
      cke_q        <= 1'b0;
      done_q       <= 1'b0;
      lock_armed_q <= 1'b0;
    end else if (fire) begin
      step_q <= step_d;
      if (step_q == ST_WAIT) cke_q        <= 1'b1;
      if (step_q == ST_EMRS) lock_armed_q <= 1'b1;
      if (step_q == ST_REF)  ref_q        <= ref_q + 1'b1;
      if (step_q == ST_DONE) done_q       <= 1'b1;
    end
  end

  ddr_init_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_VAL(MODE_VAL), .EXT_VAL(EXT_VAL)) i_enc (
    .step_i(step_q), .fire_i(fire), .cmd_o(cmd), .ba_o(ba_o), .addr_o(addr_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign cke_o       = cke_q;
  assign init_done_o = done_q;
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_i,
  input logic [3:0]        cmd_i,
  input logic [BA_W-1:0]   ba_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              done_i
);
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] MRS = 4'b0000;

  a_r1_cke_stays_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i |=> cke_i);
  a_r1_nop_while_cke_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |-> cmd_i == NOP);
  a_r10_single_cycle_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i != NOP |=> cmd_i == NOP);
  a_r3_precharge_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == PRE |-> addr_i[10]);
  a_r2_mode_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == MRS |-> (ba_i == BA_W'(0) || ba_i == BA_W'(1)));
  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_i);
  a_r9_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (cmd_i == NOP && cke_i));
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cke_i  (cke_o),
  .cmd_i  ({cs_n_o, ras_n_o, cas_n_o, we_n_o}),
  .ba_i   (ba_o),
  .addr_i (addr_o),
  .done_i (init_done_o)
);

// File: tb/test_ddr_init_seq.sv
`timescale 1ns/1ps
module test_ddr_init_seq;
  localparam int S     = 20;
  localparam int TRP   = 3;
  localparam int TRFC  = 6;
  localparam int TMRD  = 2;
  localparam int NREF  = 3;
  localparam int LCK_A = 10;
  localparam int LCK_B = 40;
  localparam logic [12:0] MODE = 13'h031;

  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  // expected schedule, derived from R3..R8
  localparam int PRE1   = S + 1;
  localparam int EMRS   = PRE1 + TRP;
  localparam int A_MRS1 = EMRS + TMRD;
  localparam int A_PRE2 = A_MRS1 + TMRD;
  localparam int A_REF0 = A_PRE2 + TRP;
  localparam int B_PRE2 = EMRS + TMRD;
  localparam int B_MRS1 = B_PRE2 + TRP;
  localparam int B_REF0 = B_MRS1 + TMRD;
  localparam int A_MRS2 = A_REF0 + NREF * TRFC;
  localparam int B_MRS2 = B_REF0 + NREF * TRFC;
  localparam int A_DONE = ((A_MRS2 + TMRD > EMRS + LCK_A) ? A_MRS2 + TMRD : EMRS + LCK_A) + 1;
  localparam int B_DONE = ((B_MRS2 + TMRD > EMRS + LCK_B) ? B_MRS2 + TMRD : EMRS + LCK_B) + 1;

  typedef struct packed {
    logic [31:0] cyc;
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] addr;
  } ev_t;

  localparam ev_t EV_A [8] = '{
    '{32'(PRE1),            C_PRE, 2'd0, 13'h400},
    '{32'(EMRS),            C_MRS, 2'd1, 13'h000},
    '{32'(A_MRS1),          C_MRS, 2'd0, MODE | 13'h100},
    '{32'(A_PRE2),          C_PRE, 2'd0, 13'h400},
    '{32'(A_REF0),          C_REF, 2'd0, 13'h000},
    '{32'(A_REF0 + TRFC),   C_REF, 2'd0, 13'h000},
    '{32'(A_REF0 + 2*TRFC), C_REF, 2'd0, 13'h000},
    '{32'(A_MRS2),          C_MRS, 2'd0, MODE & ~13'h100}
  };
  localparam ev_t EV_B [8] = '{
    '{32'(PRE1),            C_PRE, 2'd0, 13'h400},
    '{32'(EMRS),            C_MRS, 2'd1, 13'h000},
    '{32'(B_PRE2),          C_PRE, 2'd0, 13'h400},
    '{32'(B_MRS1),          C_MRS, 2'd0, MODE | 13'h100},
    '{32'(B_REF0),          C_REF, 2'd0, 13'h000},
    '{32'(B_REF0 + TRFC),   C_REF, 2'd0, 13'h000},
    '{32'(B_REF0 + 2*TRFC), C_REF, 2'd0, 13'h000},
    '{32'(B_MRS2),          C_MRS, 2'd0, MODE & ~13'h100}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke_a, cs_a, ras_a, cas_a, we_a, done_a;
  logic cke_b, cs_b, ras_b, cas_b, we_b, done_b;
  logic [1:0]  ba_a, ba_b;
  logic [12:0] addr_a, addr_b;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ddr_init_seq #(.STARTUP_CYC(S), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .DLL_LOCK(LCK_A),
                 .N_REF(NREF), .DLL_RST_FIRST(1'b1), .MODE_VAL(MODE)) i_ddr_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .cke_o(cke_a), .cs_n_o(cs_a), .ras_n_o(ras_a),
    .cas_n_o(cas_a), .we_n_o(we_a), .ba_o(ba_a), .addr_o(addr_a), .init_done_o(done_a));

  ddr_init_seq #(.STARTUP_CYC(S), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .DLL_LOCK(LCK_B),
                 .N_REF(NREF), .DLL_RST_FIRST(1'b0), .MODE_VAL(MODE)) i_ddr_init_seq_b (
    .clk_i(clk), .rst_ni(rst_n), .cke_o(cke_b), .cs_n_o(cs_b), .ras_n_o(ras_b),
    .cas_n_o(cas_b), .we_n_o(we_b), .ba_o(ba_b), .addr_o(addr_b), .init_done_o(done_b));

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int idx, input bit alt);
    case (idx)
      0: return "R3";
      1: return "R4";
      2: return alt ? "R6" : "R5";
      3: return alt ? "R5" : "R6";
      4, 5, 6: return "R7";
      7: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check_cycle(input int k);
    ev_t e_a, e_b;
    int ia, ib;
    e_a = '{32'(k), C_NOP, 2'd0, 13'h0};
    e_b = e_a;
    ia = -1;
    ib = -1;
    for (int i = 0; i < 8; i++) begin
      if (EV_A[i].cyc == 32'(k)) begin e_a = EV_A[i]; ia = i; end
      if (EV_B[i].cyc == 32'(k)) begin e_b = EV_B[i]; ib = i; end
    end
    chk({cs_a, ras_a, cas_a, we_a, ba_a, addr_a} == {e_a.cmd, e_a.ba, e_a.addr}, tag_of(ia, 1'b0),
        32'({cs_a, ras_a, cas_a, we_a, ba_a, addr_a}), 32'({e_a.cmd, e_a.ba, e_a.addr}));
    chk({cs_b, ras_b, cas_b, we_b, ba_b, addr_b} == {e_b.cmd, e_b.ba, e_b.addr}, tag_of(ib, 1'b1),
        32'({cs_b, ras_b, cas_b, we_b, ba_b, addr_b}), 32'({e_b.cmd, e_b.ba, e_b.addr}));
    chk(cke_a == (k >= S), "R1", 32'(cke_a), 32'(k >= S));
    chk(cke_b == (k >= S), "R1", 32'(cke_b), 32'(k >= S));
    chk(done_a == (k >= A_DONE), "R9", 32'(done_a), 32'(k >= A_DONE));
    chk(done_b == (k >= B_DONE), "R11", 32'(done_b), 32'(k >= B_DONE));
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({cke_a, done_a, cs_a, ras_a, cas_a, we_a} == 6'b000111, "R1",
        32'({cke_a, done_a, cs_a, ras_a, cas_a, we_a}), 32'h07);
    rst_n = 1'b1;
    // table walk: one entry per cycle since release
    for (int k = 0; k <= B_DONE + 15; k++) begin
      check_cycle(k);
      @(negedge clk);
    end
    // asynchronous reset after completion
    #2 rst_n = 1'b0;
    #1;
    chk({cke_a, done_a, cke_b, done_b} == 4'b0000, "R1",
        32'({cke_a, done_a, cke_b, done_b}), 32'h0);
    chk({cs_a, ras_a, cas_a, we_a} == C_NOP, "R9", 32'({cs_a, ras_a, cas_a, we_a}), 32'(C_NOP));
    @(negedge clk);
    rst_n = 1'b1;
    // restart must replay the cold sequence
    for (int k = 0; k <= A_PRE2 + 1; k++) begin
      check_cycle(k);
      @(negedge clk);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule